// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block sits in front of a byte-wide non-volatile memory's page-write engine and watches every byte write (address plus data) headed for it. It holds a protection flag. While the flag is clear, each write goes through to the engine unchanged. While the flag is set, writes are dropped unless they belong to a single keyed page write.

Exact address/data key sequences change the flag. Three writes set it: AAh to 1555h, then 55h to 0AAAh, then A0h to 1555h. Six writes clear it: AAh to 1555h, 55h to 0AAAh, 80h to 1555h, AAh to 1555h, 55h to 0AAAh, 20h to 1555h. A completed set sequence also opens a window in which one page of up to PAGE_BYTES data bytes is passed, and the flag stays set afterwards. Each step of a sequence, and each byte of the keyed page, has to arrive before an inter-write timeout runs out. Otherwise the partial sequence is dropped.

The flag stands in for a non-volatile latch. It starts at a parameter value and the soft reset input does not touch it.

Top module: `wpg_guard`

## Requirements
- R1: While and after rst_n is low, fwd_valid and prot_chg are 0 and the sequence matcher is idle. With default parameters, prot_on reads 0 after the first reset.
- R2: While prot_on is 0, every write (wr_valid high in a cycle) appears on fwd_valid/fwd_addr/fwd_data one clock later with the same address and data. This includes writes that form key sequences.
- R3: The three back-to-back-eligible writes AAh@1555h, 55h@0AAAh, A0h@1555h set prot_on. prot_on and prot_chg change one clock after the third write.
- R4: While prot_on is 1 and no keyed page window is open, every write is blocked (fwd_valid stays 0). This includes writes that are steps of a key sequence.
- R5: After a completed set sequence, up to PAGE_BYTES (default 64) following writes are passed while they share the page number (address bits 12 down to log2(PAGE_BYTES), bits 12..6 by default) of the first of them. A write to another page, or the write after PAGE_BYTES of them, is blocked and closes the window. prot_on stays 1.
- R6: The six writes AAh@1555h, 55h@0AAAh, 80h@1555h, AAh@1555h, 55h@0AAAh, 20h@1555h clear prot_on one clock after the sixth.
- R7: A write that is not the next expected step returns the matcher to idle and is judged as an ordinary write. A later write that would only have completed the aborted sequence has no effect.
- R8: A gap of TMO_CYC-1 idle cycles between steps keeps a sequence or an open window alive. A gap of TMO_CYC idle cycles (default 64) drops it without changing prot_on.
- R9: rst_n does not change prot_on.
- R10: prot_chg is a one-cycle pulse in exactly the cycles where prot_on has just changed. A sequence that leaves the flag at its current value gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous soft reset (does not touch the flag) |
| wr_valid | input | 1 | A byte write is presented this cycle |
| wr_addr | input | 13 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| fwd_valid | output | 1 | Registered: the write from the previous cycle is passed to the write engine |
| fwd_addr | output | 13 | Address of the passed write |
| fwd_data | output | 8 | Data of the passed write |
| prot_on | output | 1 | Protection flag |
| prot_chg | output | 1 | One-cycle pulse when prot_on has changed |

## Verification
Single plain writes, and key writes made while unprotected, tell pass-through apart from gating. The same key writes made while protected show that sequence steps are swallowed. Set and clear sequences are sent from both flag states, which separates a real flag change from a pulse raised merely because a sequence completed. A sequence broken by a wrong third byte, and sequences with gaps of exactly one cycle below and at the timeout, separate the matcher's advance, mismatch and expiry paths. A full 64-byte keyed page, an extra 65th byte and a page switch locate the window's byte count and page comparison.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,  // first key byte seen
    ST_K2   = 3'd2,  // second key byte seen
    ST_U3   = 3'd3,  // clear-path third byte seen
    ST_U4   = 3'd4,
    ST_U5   = 3'd5
  } seq_st_e;

  localparam addr_t KEY_ADDR_HI = 13'h1555;
  localparam addr_t KEY_ADDR_LO = 13'h0AAA;
  localparam byte_t KEY_FIRST   = 8'hAA;
  localparam byte_t KEY_SECOND  = 8'h55;
  localparam byte_t KEY_SET     = 8'hA0;
  localparam byte_t KEY_CLRPRE  = 8'h80;
  localparam byte_t KEY_CLR     = 8'h20;

  function automatic logic is_key(input addr_t a, input byte_t d,
                                  input addr_t ka, input byte_t kd);
    return (a == ka) && (d == kd);
  endfunction

  function automatic logic same_page(input addr_t a, input addr_t b, input int pbits);
    return (a >> pbits) == (b >> pbits);
  endfunction
endpackage

// File: rtl/wpg_matcher.sv
module wpg_matcher
  import wpg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ev,
  input  addr_t addr,
  input  byte_t data,
  input  logic  abort,
  output logic  arm_done,
  output logic  disarm_done,
  output logic  step_hit,
  output logic  busy
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    arm_done    = 1'b0;
    disarm_done = 1'b0;
    step_hit    = 1'b0;
    if (wr_ev) begin
      st_d = ST_IDLE;
      unique case (st_q)
        ST_IDLE: if (is_key(addr, data, KEY_ADDR_HI, KEY_FIRST))  begin st_d = ST_K1; step_hit = 1'b1; end
        ST_K1:   if (is_key(addr, data, KEY_ADDR_LO, KEY_SECOND)) begin st_d = ST_K2; step_hit = 1'b1; end
        ST_K2: begin
          if (is_key(addr, data, KEY_ADDR_HI, KEY_SET)) begin
            arm_done = 1'b1; step_hit = 1'b1;
          end else if (is_key(addr, data, KEY_ADDR_HI, KEY_CLRPRE)) begin
            st_d = ST_U3; step_hit = 1'b1;
          end
        end
        ST_U3:   if (is_key(addr, data, KEY_ADDR_HI, KEY_FIRST))  begin st_d = ST_U4; step_hit = 1'b1; end
        ST_U4:   if (is_key(addr, data, KEY_ADDR_LO, KEY_SECOND)) begin st_d = ST_U5; step_hit = 1'b1; end
        ST_U5: if (is_key(addr, data, KEY_ADDR_HI, KEY_CLR)) begin
          disarm_done = 1'b1; step_hit = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end else if (abort) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q != ST_IDLE);

  // R8: timer expiry drops any partial sequence
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !wr_ev |=> st_q == ST_IDLE);
  // R7: a write that is not the next step leaves the matcher idle
  p_mismatch_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev && !step_hit |=> st_q == ST_IDLE);
  // R3/R6: completion returns the matcher to idle
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_done || disarm_done) |=> st_q == ST_IDLE);
endmodule

// File: rtl/wpg_timer.sv
module wpg_timer #(
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wr_valid,
  output logic expire
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = active && !wr_valid && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (wr_valid)           cnt_q <= '0;
    else if (active && !expire)  cnt_q <= cnt_q + 1'b1;
    else                         cnt_q <= '0;
  end

  // R8: the idle count never passes the timeout limit
  p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R8: a write restarts the idle count
  p_tmo_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> cnt_q == '0);
endmodule

// File: rtl/wpg_window.sv
module wpg_window
  import wpg_pkg::*;
#(
  parameter int PAGE_BYTES = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  arm_done,
  input  logic  expire,
  input  logic  wr_valid,
  input  addr_t addr,
  output logic  take,
  output logic  open
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAGE_BYTES - 1);

  logic             open_q, have_q;
  logic [CNT_W-1:0] cnt_q;
  addr_t            base_q;

  assign open = open_q;
  assign take = open_q && wr_valid && (!have_q || same_page(addr, base_q, PAGE_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      have_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (expire) begin
      open_q <= 1'b0;
    end else if (arm_done) begin
      open_q <= 1'b1;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_valid && open_q) begin
      if (take) begin
        have_q <= 1'b1;
        base_q <= addr;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST) open_q <= 1'b0;
      end else begin
        open_q <= 1'b0;
      end
    end
  end

  // R5: the window never holds more than a page of bytes
  p_win_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> cnt_q <= LAST);
  // R5: a write that is refused closes the window
  p_win_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    open_q && wr_valid && !take && !arm_done |=> !open_q);
endmodule

// File: rtl/wpg_guard.sv
module wpg_guard
  import wpg_pkg::*;
#(
  parameter int   TMO_CYC    = 64,
  parameter int   PAGE_BYTES = 64,
  parameter logic INIT_PROT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              prot_on,
  output logic              prot_chg
);
  logic win_take, win_open, mt_ev;
  logic arm_done, disarm_done, step_hit, mt_busy;
  logic tmo_expire, pass_now;
  logic flag_q = INIT_PROT;

  assign mt_ev    = wr_valid && !win_take;
  assign pass_now = wr_valid && (win_take || !flag_q);

  wpg_matcher u_match (
    .clk(clk), .rst_n(rst_n), .wr_ev(mt_ev), .addr(wr_addr), .data(wr_data),
    .abort(tmo_expire), .arm_done(arm_done), .disarm_done(disarm_done),
    .step_hit(step_hit), .busy(mt_busy)
  );

  wpg_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(mt_busy || win_open),
    .wr_valid(wr_valid), .expire(tmo_expire)
  );

  wpg_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
    .clk(clk), .rst_n(rst_n), .arm_done(arm_done), .expire(tmo_expire),
    .wr_valid(wr_valid), .addr(wr_addr), .take(win_take), .open(win_open)
  );

  // Protection flag: no reset term, models a non-volatile latch
  always_ff @(posedge clk) begin
    if (arm_done)         flag_q <= 1'b1;
    else if (disarm_done) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
      prot_chg  <= 1'b0;
    end else begin
      fwd_valid <= pass_now;
      fwd_addr  <= wr_addr;
      fwd_data  <= wr_data;
      prot_chg  <= (arm_done && !flag_q) || (disarm_done && flag_q);
    end
  end

  assign prot_on = flag_q;

  // R4: protected and outside the window, nothing reaches the engine
  p_block_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && wr_valid && !win_open |=> !fwd_valid);
  // R2: unprotected writes are always forwarded
  p_pass_unprot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && wr_valid |=> fwd_valid);
  // R10: the pulse marks exactly the cycles after a flag change
  p_chg_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flag_q) |-> prot_chg);
  p_chg_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prot_chg |-> !$stable(flag_q));
  // R5: a keyed page leaves the flag set
  p_win_keeps_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_take |=> flag_q);
  // R3/R6: step_hit accompanies every completion
  p_done_is_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_done || disarm_done) |-> step_hit);
endmodule

// File: tb/test_wpg_guard.sv
module test_wpg_guard;
  localparam int TMO  = 64;
  localparam int PAGE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        fwd_valid, prot_on, prot_chg;
  logic [12:0] fwd_addr;
  logic [7:0]  fwd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic        s_v, s_f, s_c;
  logic [12:0] s_a;
  logic [7:0]  s_d;

  always #4 clk = ~clk;  // 125 MHz

  wpg_guard #(.TMO_CYC(TMO), .PAGE_BYTES(PAGE), .INIT_PROT(1'b0)) i_wpg_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .prot_on(prot_on), .prot_chg(prot_chg)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    s_v = fwd_valid; s_a = fwd_addr; s_d = fwd_data; s_f = prot_on; s_c = prot_chg;
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic seq_set(input int gap);
    wr(13'h1555, 8'hAA); idle(gap);
    wr(13'h0AAA, 8'h55); idle(gap);
    wr(13'h1555, 8'hA0);
  endtask

  task automatic seq_clear();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
  endtask

  task automatic t_reset();
    idle(3);
    check("R1 fwd_valid in reset", fwd_valid, 0);
    check("R1 prot_chg in reset", prot_chg, 0);
    check("R1 prot_on default", prot_on, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check("R1 fwd_valid after reset", fwd_valid, 0);
  endtask

  task automatic t_unprot();
    wr(13'h0123, 8'h5A);
    check("R2 pass valid", s_v, 1);
    check("R2 pass addr", s_a, 13'h0123);
    check("R2 pass data", s_d, 8'h5A);
    wr(13'h1555, 8'hAA);
    check("R2 key write passes unprotected", s_v, 1);
    wr(13'h1F00, 8'hC3);
    check("R2 ordinary after key", s_v, 1);
    check("R2 ordinary data", s_d, 8'hC3);
  endtask

  task automatic t_arm_unprot();
    wr(13'h1555, 8'hAA); check("R2 set step1 passes", s_v, 1);
    wr(13'h0AAA, 8'h55); check("R2 set step2 passes", s_v, 1);
    check("R3 flag not yet set", s_f, 0);
    wr(13'h1555, 8'hA0); check("R2 set step3 passes", s_v, 1);
    check("R3 flag set", s_f, 1);
    check("R10 pulse on set", s_c, 1);
    idle(1);
    check("R10 pulse one cycle", prot_chg, 0);
    idle(TMO);
  endtask

  task automatic t_prot_block();
    wr(13'h0200, 8'h33);
    check("R4 ordinary blocked", s_v, 0);
    wr(13'h1555, 8'hAA);
    check("R4 key step blocked", s_v, 0);
    wr(13'h0201, 8'h34);
    check("R4 mismatch blocked", s_v, 0);
  endtask

  task automatic t_mismatch();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'h11);
    check("R7 wrong third byte blocked", s_v, 0);
    wr(13'h1555, 8'hA0);
    check("R7 late completion blocked", s_v, 0);
    wr(13'h0400, 8'h44);
    check("R7 no window after broken sequence", s_v, 0);
    check("R7 flag unchanged", s_f, 1);
  endtask

  task automatic t_keyed_page();
    int miss = 0;
    seq_set(0);
    check("R4 set steps blocked while protected", s_v, 0);
    check("R10 no pulse when already set", s_c, 0);
    for (int i = 0; i < PAGE; i++) begin
      wr(13'h0140 + 13'(i), 8'(i ^ 8'h5C));
      if (!(s_v && s_a == 13'h0140 + 13'(i) && s_d == 8'(i ^ 8'h5C))) miss++;
    end
    check("R5 full page passed", miss, 0);
    check("R5 flag stays set", s_f, 1);
    wr(13'h0140, 8'hEE);
    check("R5 byte past page size blocked", s_v, 0);
  endtask

  task automatic t_page_switch();
    seq_set(0);
    wr(13'h0300, 8'h01); check("R5 first window byte passes", s_v, 1);
    wr(13'h0380, 8'h02); check("R5 other page blocked", s_v, 0);
    wr(13'h0301, 8'h03); check("R5 window closed after switch", s_v, 0);
  endtask

  task automatic t_timeout();
    seq_set(TMO - 1);
    wr(13'h0600, 8'h66);
    check("R8 gap TMO-1 keeps sequence", s_v, 1);
    idle(TMO - 1);
    wr(13'h0601, 8'h67);
    check("R8 gap TMO-1 keeps window", s_v, 1);
    idle(TMO);
    wr(13'h0602, 8'h68);
    check("R8 window expired", s_v, 0);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); idle(TMO);
    wr(13'h1555, 8'hA0);
    wr(13'h0700, 8'h70);
    check("R8 gap TMO drops sequence", s_v, 0);
    check("R8 flag unchanged by expiry", s_f, 1);
  endtask

  task automatic t_disarm();
    wr(13'h0001, 8'h00);
    seq_clear();
    check("R4 clear step blocked", s_v, 0);
    check("R6 flag cleared", s_f, 0);
    check("R10 pulse on clear", s_c, 1);
    wr(13'h0555, 8'h77);
    check("R6 write passes after clear", s_v, 1);
    check("R6 passed data", s_d, 8'h77);
    seq_clear();
    check("R2 clear steps pass unprotected", s_v, 1);
    check("R10 no pulse when already clear", s_c, 0);
    check("R6 flag still clear", s_f, 0);
  endtask

  task automatic t_reset_keep();
    seq_set(0);
    check("R3 set again", s_f, 1);
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    check("R9 flag held in reset", prot_on, 1);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    check("R9 flag kept after reset", prot_on, 1);
    check("R1 fwd_valid after soft reset", fwd_valid, 0);
    wr(13'h0800, 8'h88);
    check("R1 window cleared by reset", s_v, 0);
    idle(TMO);
    seq_clear();
    check("R6 final clear", s_f, 0);
  endtask

  initial begin
    t_reset();
    t_unprot();
    t_arm_unprot();
    t_prot_block();
    t_mismatch();
    t_keyed_page();
    idle(TMO);
    t_page_switch();
    idle(TMO);
    t_timeout();
    idle(TMO);
    t_disarm();
    t_reset_keep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule